// File: doc/BRIEF.md
# Serial Address-Match Wake-Up Controller

This block is the control unit of a serial channel that can run as a three-wire port or as a two-wire addressed bus. It holds the channel's mode and control register and a slave address register. It picks one of three shift-clock sources, and it turns each byte-received event into an interrupt request. When the wake-up option is on in two-wire mode, the interrupt stays quiet until the first byte after a start condition carries the programmed slave address. A sleeping processor is therefore woken only for traffic meant for it.

The processor reaches four byte-wide locations through a simple port. The read data is combinational on the select lines and writes take effect on the clock edge.

| Select | Location |
|---|---|
| 0 | Control |
| 1 | Slave address |
| 2 | Transmit data |
| 3 | Status, with the sticky error in bit 0 |

The control byte is laid out as follows:

| Bits | Field |
|---|---|
| 7 | Channel enable |
| 6 | Address-match flag, read only |
| 5 | Wake-up enable |
| 4:2 | Mode |
| 1:0 | Clock source |

The bit shifter, the start and stop detector, and the pad logic sit outside the block. They report a finished byte with a one-cycle strobe that carries the byte, and they report a start condition with a one-cycle flag.

Top module: `sbus_wake_ctrl`

## Requirements
- R1: After reset, every location reads 00H, and `irq`, `tx_load` and `shift_tick` are 0.
- R2: A write to select 0 stores bits 7, 5 and 4:0 and ignores bit 6. A read of select 0 returns {enable, match flag, wake-up, mode[2:0], source[1:0]}.
- R3: Clock source selection:
  - When the channel is disabled, `shift_tick` is 0.
  - Source 00 or 01 passes `ext_tick`.
  - Source 11 passes `pre_tick`.
  - Source 10 passes `tmr_tick` while mode bit 4 is 0.
- R4: With the channel enabled, source 10 and mode bit 4 set, `shift_tick` pulses on every sixteenth `tmr_tick`. The counter starts from zero each time this combination becomes active.
- R5: With wake-up 0, every `rx_done` seen while the channel is enabled raises `irq` in the following cycle.
- R6: With wake-up 1 and mode bit 4 set, `irq` follows an `rx_done` only when these conditions all hold:
  - The byte is the first one since a `start_det`.
  - The byte equals the slave address.

  When `start_det` and `rx_done` fall in the same cycle, that byte is judged as not being the first one, and the next byte becomes the first.
- R7: With wake-up 1 and mode bit 4 clear (three-wire mode), every `rx_done` raises `irq`, as with wake-up 0.
- R8: The match flag takes the value (`rx_byte` == slave address) in the cycle after each `rx_done`. It reads 0 whenever the enable bit is 0.
- R9: Writes to select 2 behave according to wake-up:
  - With wake-up 0, the written byte appears on `tx_byte`, and `tx_load` pulses for one cycle in the next cycle.
  - With wake-up 1, the write is ignored and sets the sticky error bit (select 3, bit 0).
  - Writing select 3 with bit 0 set clears the error bit.
- R10: `irq` is a one-cycle pulse per qualifying byte and is never raised in the cycle after the enable bit reads 0.
- R11: `bus_mode` equals mode bit 4. `lane_sel` equals mode bit 3 when mode bit 4 is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_sel` |
| rx_done | input | 1 | One-cycle strobe: byte received |
| rx_byte | input | 8 | Received shift-register byte |
| start_det | input | 1 | One-cycle strobe: start condition seen |
| ext_tick | input | 1 | External clock tick |
| tmr_tick | input | 1 | Timer output tick |
| pre_tick | input | 1 | Prescaler tick |
| shift_tick | output | 1 | Selected shift-clock tick |
| bus_mode | output | 1 | Two-wire mode active |
| lane_sel | output | 1 | Data-line choice in two-wire mode |
| tx_byte | output | 8 | Byte to transmit |
| tx_load | output | 1 | One-cycle pulse: new transmit byte |
| irq | output | 1 | Interrupt request pulse |

## Verification
The hardest state to reach from the ports is the armed window of the wake-up mode. A start flag must come first and the next byte is the only one judged, so the stimulus needs several orderings:
- a matching first byte followed by a matching second byte;
- a mismatching first byte followed by a matching second byte;
- a start that coincides with a byte strobe;
- a channel disable that falls between the start and the byte.

A directed sequence builds each of these orderings. A long random run then mixes start flags, strobes and mode writes so that the armed state is entered and left in orders the directed part does not list.

// File: rtl/sbus_wake_pkg.sv
package sbus_wake_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SVA  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  typedef enum logic [1:0] {
    CKS_EXT0 = 2'd0,
    CKS_EXT1 = 2'd1,
    CKS_TMR  = 2'd2,
    CKS_PRE  = 2'd3
  } cks_e;

  typedef struct packed {
    logic       en;
    logic       wake;
    logic [2:0] mode;
    logic [1:0] cks;
  } ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(ctrl_t c, logic match);
    return {c.en, match & c.en, c.wake, c.mode, c.cks};
  endfunction

  function automatic ctrl_t byte_to_ctrl(logic [7:0] d);
    ctrl_t c;
    c.en   = d[7];
    c.wake = d[5];
    c.mode = d[4:2];
    c.cks  = d[1:0];
    return c;
  endfunction

  function automatic logic is_bus(ctrl_t c);
    return c.mode[2];
  endfunction

endpackage

// File: rtl/sbus_regs.sv
module sbus_regs
  import sbus_wake_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          match_flag,
  output logic [DW-1:0] cpu_rdata,
  output ctrl_t         ctrl,
  output logic [DW-1:0] sva,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          err
);

  logic wr_ctrl, wr_sva, wr_data, wr_stat, data_blocked;
  assign wr_ctrl      = cpu_wr && (cpu_sel == SEL_CTRL);
  assign wr_sva       = cpu_wr && (cpu_sel == SEL_SVA);
  assign wr_data      = cpu_wr && (cpu_sel == SEL_DATA);
  assign wr_stat      = cpu_wr && (cpu_sel == SEL_STAT);
  assign data_blocked = wr_data && ctrl.wake;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      sva     <= '0;
      tx_byte <= '0;
      tx_load <= 1'b0;
      err     <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (wr_ctrl) ctrl <= byte_to_ctrl(cpu_wdata);
      if (wr_sva)  sva  <= cpu_wdata;
      if (data_blocked) begin
        err <= 1'b1;
      end else if (wr_data) begin
        tx_byte <= cpu_wdata;
        tx_load <= 1'b1;
      end
      if (wr_stat && cpu_wdata[0]) err <= 1'b0;
    end
  end

  always_comb begin
    unique case (cpu_sel)
      SEL_CTRL: cpu_rdata = ctrl_to_byte(ctrl, match_flag);
      SEL_SVA:  cpu_rdata = sva;
      SEL_DATA: cpu_rdata = tx_byte;
      default:  cpu_rdata = {{(DW-1){1'b0}}, err};
    endcase
  end

  // R9: a blocked data write leaves the transmit byte and raises the error
  p_wdata_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_blocked |=> (tx_byte == $past(tx_byte)) && err && !tx_load);

  // R9: the error bit stays set until cleared by the status port
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(wr_stat && cpu_wdata[0])) |=> err);

  // R2: a control write never alters bits other than through the field map
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl));

endmodule

// File: rtl/sbus_clk_sel.sv
module sbus_clk_sel
  import sbus_wake_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       bus,
  input  logic [1:0] cks,
  input  logic       ext_tick,
  input  logic       tmr_tick,
  input  logic       pre_tick,
  output logic       shift_tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic          div_active, div_wrap;
  logic [CW-1:0] div_cnt;

  assign div_active = en && bus && (cks == CKS_TMR);
  assign div_wrap   = div_active && tmr_tick && (div_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !div_active) begin
      div_cnt <= '0;
    end else if (tmr_tick) begin
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end
  end

  always_comb begin
    shift_tick = 1'b0;
    if (en) begin
      unique case (cks)
        CKS_EXT0, CKS_EXT1: shift_tick = ext_tick;
        CKS_PRE:            shift_tick = pre_tick;
        default:            shift_tick = bus ? div_wrap : tmr_tick;
      endcase
    end
  end

  // R3: no tick leaves a disabled channel
  p_tick_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_tick |-> en);

  // R4: in divided mode every tick coincides with a timer tick
  p_div_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_active && shift_tick) |-> tmr_tick);

  // R4: the divider restarts from zero once the divided mode is left
  p_div_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_active |=> (div_cnt == '0));

endmodule

// File: rtl/sbus_match.sv
module sbus_match
  import sbus_wake_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wake,
  input  logic          bus,
  input  logic [DW-1:0] sva,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          start_det,
  output logic          match_flag,
  output logic          irq
);

  logic armed, addr_hit, wake_gate, irq_next;

  assign addr_hit  = (rx_byte == sva);
  assign wake_gate = wake && bus;
  assign irq_next  = en && rx_done && (!wake_gate || (armed && addr_hit));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      armed      <= 1'b0;
      match_flag <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= irq_next;
      if (rx_done) match_flag <= addr_hit;
      if (start_det)    armed <= 1'b1;
      else if (rx_done) armed <= 1'b0;
    end
  end

  // R5: every request follows a received byte
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_done));

  // R6: a byte outside the armed window never wakes the bus mode
  p_wake_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wake_gate && rx_done && !armed) |=> !irq);

  // R8: the match flag is cleared while disabled
  p_flag_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !match_flag);

  // R10: a disabled channel raises no request
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);

endmodule

// File: rtl/sbus_wake_ctrl.sv
module sbus_wake_ctrl
  import sbus_wake_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DIV = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          start_det,
  input  logic          ext_tick,
  input  logic          tmr_tick,
  input  logic          pre_tick,
  output logic          shift_tick,
  output logic          bus_mode,
  output logic          lane_sel,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          irq
);

  ctrl_t         ctrl;
  logic [DW-1:0] sva;
  logic          match_flag, err;

  assign bus_mode = is_bus(ctrl);
  assign lane_sel = is_bus(ctrl) && ctrl.mode[1];

  sbus_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .match_flag(match_flag), .cpu_rdata(cpu_rdata),
    .ctrl(ctrl), .sva(sva), .tx_byte(tx_byte), .tx_load(tx_load), .err(err)
  );

  sbus_clk_sel #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .bus(bus_mode), .cks(ctrl.cks),
    .ext_tick(ext_tick), .tmr_tick(tmr_tick), .pre_tick(pre_tick),
    .shift_tick(shift_tick)
  );

  sbus_match #(.DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .wake(ctrl.wake), .bus(bus_mode),
    .sva(sva), .rx_done(rx_done), .rx_byte(rx_byte), .start_det(start_det),
    .match_flag(match_flag), .irq(irq)
  );

  // R11: the data-line choice only shows in two-wire mode
  p_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lane_sel |-> bus_mode);

endmodule

// File: tb/sbus_wake_ctrl_bench.sv
`timescale 1ns/1ps
module sbus_wake_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_wr;
  logic [1:0] cpu_sel;
  logic [7:0] cpu_wdata, cpu_rdata, rx_byte, tx_byte;
  logic       rx_done, start_det, ext_tick, tmr_tick, pre_tick;
  logic       shift_tick, bus_mode, lane_sel, tx_load, irq;

  always #2.5 clk = ~clk;

  sbus_wake_ctrl u_sbus_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_done(rx_done),
    .rx_byte(rx_byte), .start_det(start_det), .ext_tick(ext_tick),
    .tmr_tick(tmr_tick), .pre_tick(pre_tick), .shift_tick(shift_tick),
    .bus_mode(bus_mode), .lane_sel(lane_sel), .tx_byte(tx_byte),
    .tx_load(tx_load), .irq(irq)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Reference state, kept as plain bench variables
  bit m_en, m_wake, m_flag, m_err, m_load, m_irq, m_first;
  bit [2:0] m_mode;
  bit [1:0] m_src;
  bit [7:0] m_addr, m_tx;
  int m_ticks;

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit ref_tick();
    if (!m_en) return 0;                       // R3
    if (m_src[1] == 1'b0) return ext_tick;     // R3
    if (m_src == 2'b11) return pre_tick;       // R3
    if (!m_mode[2]) return tmr_tick;           // R3
    return tmr_tick && (m_ticks == 15);        // R4
  endfunction

  function automatic int ref_read();
    case (cpu_sel)
      2'd0: return {m_en, m_flag && m_en, m_wake, m_mode, m_src};  // R2
      2'd1: return m_addr;
      2'd2: return m_tx;
      default: return {7'd0, m_err};                              // R9
    endcase
  endfunction

  task automatic compare_all();
    check("R3", "shift_tick", shift_tick, ref_tick());
    check("R2", "cpu_rdata", cpu_rdata, ref_read());
    check("R6", "irq", irq, m_irq);
    check("R9", "tx_byte", tx_byte, m_tx);
    check("R9", "tx_load", tx_load, m_load);
    check("R11", "bus_mode", bus_mode, m_mode[2]);
    check("R11", "lane_sel", lane_sel, m_mode[2] && m_mode[1]);
  endtask

  task automatic model_edge();
    bit n_irq;
    if (!rst_n) begin
      {m_en, m_wake, m_flag, m_err, m_load, m_irq, m_first} = '0;
      m_mode = 0; m_src = 0; m_addr = 0; m_tx = 0; m_ticks = 0;
      return;
    end
    // R5 R7 R6: request rules
    if (!m_en || !rx_done) n_irq = 0;
    else if (m_wake && m_mode[2]) n_irq = m_first && (rx_byte == m_addr);
    else n_irq = 1;
    if (!m_en) begin
      m_flag = 0; m_first = 0;
    end else begin
      if (rx_done) m_flag = (rx_byte == m_addr);  // R8
      if (start_det) m_first = 1;
      else if (rx_done) m_first = 0;
    end
    if (m_en && m_mode[2] && m_src == 2'b10) begin
      if (tmr_tick) m_ticks = (m_ticks + 1) % 16;
    end else m_ticks = 0;
    m_irq = n_irq;
    m_load = 0;
    if (cpu_wr) begin
      case (cpu_sel)
        2'd0: begin m_en = cpu_wdata[7]; m_wake = cpu_wdata[5];
                    m_mode = cpu_wdata[4:2]; m_src = cpu_wdata[1:0]; end
        2'd1: m_addr = cpu_wdata;
        2'd2: if (m_wake) m_err = 1; else begin m_tx = cpu_wdata; m_load = 1; end
        default: if (cpu_wdata[0]) m_err = 0;
      endcase
    end
  endtask

  task automatic cyc(bit wr = 0, bit [1:0] sel = 0, bit [7:0] wd = 0,
                     bit rx = 0, bit [7:0] rb = 0, bit st = 0,
                     bit et = 0, bit tt = 0, bit pt = 0);
    @(negedge clk);
    cpu_wr = wr; cpu_sel = sel; cpu_wdata = wd;
    rx_done = rx; rx_byte = rb; start_det = st;
    ext_tick = et; tmr_tick = tt; pre_tick = pt;
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr_reg(bit [1:0] sel, bit [7:0] d);
    cyc(1, sel, d);
  endtask

  task automatic rd_reg(bit [1:0] sel);
    cyc(0, sel);
  endtask

  initial begin
    #(5 * 20000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1;
    // R1: every location and output is zero after reset
    for (int s = 0; s < 4; s++) cyc(0, 2'(s), 0, 0, 0, 0, 1, 1, 1);

    // R3: source selection in three-wire mode
    wr_reg(0, 8'h80);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, i[0], 1, 0);
    wr_reg(0, 8'h83);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, i[0]);
    wr_reg(0, 8'h82);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, i[0], 1);

    // R4 R11: divided timer clock in two-wire mode, both data lines
    wr_reg(0, 8'h92);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 0, 0, i[0], 0);
    wr_reg(0, 8'h9A);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R5 R8: wake-up off, a request per byte, flag tracks the compare
    wr_reg(1, 8'h5A);
    wr_reg(0, 8'h90);
    cyc(0, 0, 0, 1, 8'h5A); rd_reg(0);
    cyc(0, 0, 0, 1, 8'h11); cyc(0, 0, 0, 1, 8'h5A); rd_reg(0);

    // R2: bit 6 of a control write is ignored
    wr_reg(0, 8'hD0); rd_reg(0); wr_reg(0, 8'h50); rd_reg(0);

    // R6: wake-up in two-wire mode
    wr_reg(0, 8'hB0);
    cyc(0, 0, 0, 1, 8'h5A);                   // no start yet
    cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 1, 8'h5A); cyc(0, 0, 0, 1, 8'h5A);
    cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 1, 8'h33); cyc(0, 0, 0, 1, 8'h5A);
    cyc(0, 0, 0, 1, 8'h5A, 1); cyc(0, 0, 0, 1, 8'h5A);  // coincident start
    cyc(0, 0, 0, 0, 0, 1); wr_reg(0, 8'h30); wr_reg(0, 8'hB0);
    cyc(0, 0, 0, 1, 8'h5A);                   // disable dropped the window
    // R10: back-to-back qualifying bytes give separate pulses
    wr_reg(0, 8'h90);
    cyc(0, 0, 0, 1, 8'h01); cyc(0, 0, 0, 1, 8'h02); cyc();

    // R7: wake-up in three-wire mode behaves like wake-up off
    wr_reg(0, 8'hA0);
    cyc(0, 0, 0, 1, 8'h77); cyc(0, 0, 0, 1, 8'h5A); cyc();

    // R9: data writes blocked by wake-up, error bit sticky and clearable
    wr_reg(2, 8'hC3); rd_reg(3); rd_reg(2);
    wr_reg(3, 8'h00); rd_reg(3); wr_reg(3, 8'h01); rd_reg(3);
    wr_reg(0, 8'h80); wr_reg(2, 8'h3C); rd_reg(2); rd_reg(3);

    // R8 R10: disabled channel clears flag and raises nothing
    cyc(0, 0, 0, 1, 8'h5A); rd_reg(0);
    wr_reg(0, 8'h10); rd_reg(0); cyc(0, 0, 0, 1, 8'h5A); cyc(0, 0, 0, 0, 0, 0, 1, 1, 1);

    // Random mix of strobes, starts and mode writes
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] r = 8'($urandom);
      cyc(($urandom % 10) == 0, 2'($urandom), r[7] ? 8'($urandom) : {r[6], 1'b0, r[5:0]},
          ($urandom % 3) == 0, ($urandom % 2) ? 8'h5A : 8'($urandom % 4 + 8'h59),
          ($urandom % 5) == 0, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule